// File: doc/BRIEF.md
# Lookahead Pipelined First-Order Recursive Filter

This block is a first-order recursive low-pass or high-pass section whose output follows y(n) = x(n) + A·y(n-1), with a fixed signed Q1.15 coefficient A set at elaboration. The recursion is unrolled by one sample. Each output is formed as x(n) + A·x(n-1) + A²·y(n-2). A² is a constant worked out at elaboration. The feedback loop therefore spans two registers. The multiplier and the adder sit on opposite sides of the second register, and neither is ever in series with the other inside one cycle.

One sample may enter per clock on a valid-qualified stream. Each accepted sample produces exactly one output one clock later. When valid is low, the filter history is frozen. The feed-forward product A·x(n-1) is registered outside the loop. The feedback product A²·y(n-1) is registered and consumed one sample later as A²·y(n-2).

Top module: `iir_lookahead`

## Requirements
- R1: While rst_ni is low and after its release, y_o is 0 and valid_o is 0. The stored x(n-1), y(n-1) and y(n-2) are all 0, so the first output after reset equals the first input.
- R2: valid_o is high in exactly the cycles that follow a clock edge where valid_i was high. In those cycles y_o carries the output for the sample accepted at that edge.
- R3: For each accepted sample n, y(n) = x(n) + A·x(n-1) + A²·y(n-2), indexed by accepted samples. With exact products this equals x(n) + A·y(n-1). For A = 0.75 (0x6000) and the impulse 0x4000, 0, 0, 0, 0, 0, the outputs are 0x4000, 0x3000, 0x2400, 0x1B00, 0x1440, 0x0F30.
- R4: Data and coefficients are signed two's complement Q1.15 (16 bits). Each product is c·d / 2^15 rounded toward minus infinity and is kept without saturation. The three terms are summed at full width.
- R5: The sum saturates to 0x7FFF when above it and to 0x8000 when below it. A positive input with non-negative terms never yields a negative output, and the reverse holds for negative values.
- R6: A² is the constant floor(A·A / 2^15), clipped to 0x7FFF. For A = -0.5 (0xC000), A² = 0x2000, and the impulse 0x4000 gives 0x4000, 0xE000, 0x1000, 0xF800.
- R7: In a cycle with valid_i low, no history advances. In the following cycle valid_o is 0 and y_o holds its last value. The next accepted sample continues the recurrence as if the gap were absent.
- R8: Asserting rst_ni in mid-stream clears all history. A following impulse reproduces the R3 sequence exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample qualifier |
| x_i | input | DATA_W | Input sample, signed Q1.15 |
| valid_o | output | 1 | Output sample qualifier |
| y_o | output | DATA_W | Filtered sample, signed Q1.15 |

## Verification
An impulse into the 0.75 filter gives products that are exact. It therefore separates correct use of A·x(n-1) and A²·y(n-2) from a swapped, missing or one-sample-misaligned term. A second instance with a negative coefficient shows the alternating-sign response and checks the precomputed A² on a sign change. A mixed pattern of odd values is compared against the quantised model bit by bit, which exposes rounding direction. Runs of full-scale positive and negative input exercise both saturation limits. Stalls within the stream show whether history freezes, and a reset in mid-stream shows whether it is cleared.

// File: rtl/iir_pkg.sv
package iir_pkg;
  // clip a constant to a signed w-bit range
  function automatic longint clip_sym(longint v, int unsigned w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction
endpackage

// File: rtl/iir_coef_tap.sv
module iir_coef_tap #(
  parameter int unsigned DATA_W = 16,
  parameter logic signed [DATA_W-1:0] COEF = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] d_i,
  output logic signed [DATA_W:0]   q_o
);
  localparam int unsigned FRAC_W = DATA_W - 1;
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] prod_sh;

  assign prod    = d_i * COEF;
  assign prod_sh = prod >>> FRAC_W;  // floor

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (en_i) q_o <= prod_sh[DATA_W:0];
  end
endmodule

// File: rtl/iir_sat_add.sv
module iir_sat_add #(
  parameter int unsigned DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W:0]   a_i,
  input  logic signed [DATA_W:0]   b_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int unsigned SUM_W = DATA_W + 3;
  localparam logic signed [SUM_W-1:0] SAT_HI = {4'b0000, {(DATA_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] SAT_LO = {4'b1111, {(DATA_W-1){1'b0}}};

  logic signed [SUM_W-1:0] sum;

  assign sum = {{3{x_i[DATA_W-1]}}, x_i}
             + {{2{a_i[DATA_W]}}, a_i}
             + {{2{b_i[DATA_W]}}, b_i};

  always_comb begin
    if (sum > SAT_HI)      y_o = {1'b0, {(DATA_W-1){1'b1}}};
    else if (sum < SAT_LO) y_o = {1'b1, {(DATA_W-1){1'b0}}};
    else                   y_o = sum[DATA_W-1:0];
  end
endmodule

// File: rtl/iir_lookahead.sv
module iir_lookahead #(
  parameter int unsigned DATA_W = 16,
  parameter logic signed [DATA_W-1:0] COEF_A = 16'sh6000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] x_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int unsigned FRAC_W = DATA_W - 1;
  localparam longint A2_FULL = (longint'(COEF_A) * longint'(COEF_A)) >>> FRAC_W;
  localparam logic signed [DATA_W-1:0] COEF_A2 =
    DATA_W'(iir_pkg::clip_sym(A2_FULL, DATA_W));

  logic signed [DATA_W:0]   ff_term;  // A*x(n-1)
  logic signed [DATA_W:0]   fb_term;  // A2*y(n-2)
  logic signed [DATA_W-1:0] y_next;
  logic signed [DATA_W-1:0] y_q;
  logic                     valid_q;

  // feed-forward tap, outside the loop
  iir_coef_tap #(.DATA_W(DATA_W), .COEF(COEF_A)) u_ff_tap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .d_i   (x_i),
    .q_o   (ff_term)
  );

  // loop register retimed between multiplier and adder
  iir_coef_tap #(.DATA_W(DATA_W), .COEF(COEF_A2)) u_fb_tap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .d_i   (y_q),
    .q_o   (fb_term)
  );

  iir_sat_add #(.DATA_W(DATA_W)) u_sum (
    .x_i(x_i),
    .a_i(ff_term),
    .b_i(fb_term),
    .y_o(y_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) y_q <= y_next;
    end
  end

  assign y_o     = y_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/iir_lookahead_chk.sv
module iir_lookahead_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic signed [DATA_W-1:0] x_i,
  input logic signed [DATA_W:0]   ff_term,
  input logic signed [DATA_W:0]   fb_term,
  input logic                     valid_o,
  input logic signed [DATA_W-1:0] y_o
);
  assert_valid_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_no_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_o));

  assert_no_wrap_pos_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !x_i[DATA_W-1] && !ff_term[DATA_W] && !fb_term[DATA_W])
      |=> !y_o[DATA_W-1]);

  assert_no_wrap_neg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && x_i[DATA_W-1] && ff_term[DATA_W] && fb_term[DATA_W])
      |=> y_o[DATA_W-1]);
endmodule

bind iir_lookahead iir_lookahead_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .x_i    (x_i),
  .ff_term(ff_term),
  .fb_term(fb_term),
  .valid_o(valid_o),
  .y_o    (y_o)
);

// File: tb/tb_iir_lookahead.sv
`timescale 1ns/1ps
module tb_iir_lookahead;
  localparam int VEC_N = 6;
  localparam int VEC_X [VEC_N] = '{16384, 0, 0, 0, 0, 0};
  localparam int VEC_Y [VEC_N] = '{16'h4000, 16'h3000, 16'h2400, 16'h1B00, 16'h1440, 16'h0F30};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [15:0] x_i = '0;
  logic v0, v1;
  logic signed [15:0] y0, y1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int coef [2] = '{24576, -16384};
  int coef2 [2];
  int m_x1 [2];
  int m_y1 [2];
  int m_y2 [2];
  int last_y [2];

  always #4 clk = ~clk;

  iir_lookahead #(.DATA_W(16), .COEF_A(16'sh6000)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i),
    .valid_o(v0), .y_o(y0));

  iir_lookahead #(.DATA_W(16), .COEF_A(-16'sd16384)) dut_neg (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .x_i(x_i),
    .valid_o(v1), .y_o(y1));

  function automatic int mq(int c, int d);
    longint p;
    p = longint'(c) * longint'(d);
    return int'(p >>> 15);
  endfunction

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_x1[k] = 0; m_y1[k] = 0; m_y2[k] = 0; last_y[k] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    @(negedge clk);
    chk("R1 y_o in reset", int'(y0), 0);
    chk("R1 valid_o in reset", int'(v0), 0);
    chk("R8 neg y_o in reset", int'(y1), 0);
    rst_ni = 1'b1;
    model_reset();
  endtask

  // drive at a negedge, check at the next negedge
  task automatic step(input bit v, input int x, input string req);
    int exp [2];
    valid_i = v;
    x_i = x[15:0];
    for (int k = 0; k < 2; k++) begin
      if (v) begin
        exp[k] = sat16(x + mq(coef[k], m_x1[k]) + mq(coef2[k], m_y2[k]));
        m_y2[k] = m_y1[k]; m_y1[k] = exp[k]; m_x1[k] = x;
        last_y[k] = exp[k];
      end else begin
        exp[k] = last_y[k];
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk({req, " y_o"}, int'(y0), exp[0]);
    chk({req, " valid_o"}, int'(v0), int'(v));
    chk({req, " neg y_o"}, int'(y1), exp[1]);
    chk({req, " neg valid_o"}, int'(v1), int'(v));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) coef2[k] = sat16(mq(coef[k], coef[k]));
    model_reset();
    @(negedge clk);
    do_reset();
    step(1'b0, 0, "R1 idle");

    // R3: impulse table, exact products
    for (int i = 0; i < VEC_N; i++) begin
      step(1'b1, VEC_X[i], "R3 impulse");
      chk("R3 table", int'(y0), VEC_Y[i] > 32767 ? VEC_Y[i] - 65536 : VEC_Y[i]);
    end

    // R6: negative coefficient impulse, hand values
    do_reset();
    step(1'b1, 16384, "R6 imp");  chk("R6 y0", int'(y1), 16384);
    step(1'b1, 0, "R6 imp");      chk("R6 y1", int'(y1), -8192);
    step(1'b1, 0, "R6 imp");      chk("R6 y2", int'(y1), 4096);
    step(1'b1, 0, "R6 imp");      chk("R6 y3", int'(y1), -2048);

    // R4: odd values, rounding toward minus infinity
    begin
      int pat [10] = '{12345, -7777, 3, -1, 20001, -19999, 555, -32001, 17, 9};
      for (int i = 0; i < 10; i++) step(1'b1, pat[i], "R4 mixed");
    end

    // R5: saturation both ways
    for (int i = 0; i < 6; i++) step(1'b1, 32767, "R5 sat hi");
    chk("R5 clip hi", int'(y0), 32767);
    for (int i = 0; i < 6; i++) step(1'b1, -32768, "R5 sat lo");
    chk("R5 clip lo", int'(y0), -32768);

    // R7: gaps in the stream
    step(1'b1, 1000, "R7 pre");
    step(1'b0, 31000, "R7 gap");
    step(1'b0, -31000, "R7 gap");
    step(1'b1, -2000, "R7 post");
    step(1'b0, 5, "R7 gap");
    step(1'b1, 0, "R7 post");
    step(1'b1, 0, "R7 post");

    // R8: reset in mid-stream, impulse again
    step(1'b1, 22222, "R8 pre");
    do_reset();
    for (int i = 0; i < VEC_N; i++) begin
      step(1'b1, VEC_X[i], "R8 after reset");
      chk("R8 table", int'(y0), VEC_Y[i]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule